// File: doc/BRIEF.md
# Unlock-Gated Program Bank Mapper

This block turns register writes from a serially loaded configuration file into two 16 KB program-ROM window assignments covering CPU addresses 0x8000 to 0xFFFF. Each time the register file finishes a write it pulses an update strobe. The mapper then recomputes the bank number for both windows from four inputs: a 5-bit control byte, a program bank register, a program-mode flag and a bank-select flag.

Banking stays frozen at the first 32 KB of ROM until control bit 4 goes through a two-step key. The key needs one update with the bit low, followed later by an update with the bit high. After that the lock stays open until reset. An outer field in control bit 3 selects one half of a 256 KB space. The inner 3-bit bank number comes from the control byte when that outer field is clear, and from the program bank register when it is set.

The block also forms a ROM address. Address bit 14 picks the window, and address bits 13:0 pass through as the offset within that window.

Top module: `gated_prg_mapper`

## Requirements
- R1: Reset puts the lock in its first locked state (waiting for a low key bit) and sets the window banks to 0 and 1. This is the same result as recomputing with a control byte of 0x10.
- R2: While the lock is in either locked state, every update leaves window 0 at bank 0 and window 1 at bank 1, whatever the register values.
- R3: In the first locked state, an update with control bit 4 = 1 leaves the lock unchanged. An update with bit 4 = 0 moves it to the second locked state.
- R4: In the second locked state, an update with control bit 4 = 0 leaves the lock unchanged. An update with bit 4 = 1 opens it, and that same update's register values already set the banks.
- R5: Once open, the lock stays open for any later update until reset.
- R6: The outer value is 8 when control bit 3 is 1, and 0 otherwise. The inner bank is control bits 2:0 when the outer value is 0, and program bank register bits 2:0 otherwise. Bit 3 of the program bank register is never used.
- R7: When unlocked, with the program-mode flag set, the outer value 8 and the bank-select flag set, window 0 gets inner|8 and window 1 gets 15.
- R8: When unlocked, with the program-mode flag set, the outer value 8 and the bank-select flag clear, window 0 gets 8 and window 1 gets inner|8.
- R9: When unlocked in every other case (32 KB mode), window 0 gets (inner with bit 0 cleared)|outer and window 1 gets that value plus one.
- R10: Bank outputs are registered. They change only at the clock edge where the update strobe is sampled high, or on reset.
- R11: romAddr is {bank, cpuAddr[13:0]}, where the bank is window 1's bank when cpuAddr[14] is 1 and window 0's bank otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| updStrobe | input | 1 | One-cycle pulse marking a completed register write |
| ctrlByte | input | 5 | Control byte; bit 4 is the key bit, bit 3 the outer field, bits 2:0 an inner source |
| prgBank | input | 4 | Program bank register; bits 2:0 are an inner source |
| prgMode | input | 1 | Program-mode flag enabling the split 16 KB layouts |
| bankSel | input | 1 | Chooses between the two split layouts |
| cpuAddr | input | 15 | CPU address bits 14:0 inside 0x8000-0xFFFF |
| win0Bank | output | 4 | 16 KB bank for window 0 (0x8000-0xBFFF) |
| win1Bank | output | 4 | 16 KB bank for window 1 (0xC000-0xFFFF) |
| romAddr | output | 18 | Physical ROM byte address |

## Verification
The lock state and the bank registers both update on the clock edge that samples the strobe. The new banks are therefore readable one edge after the strobe is presented, and the bench drives each strobe for exactly one cycle between falling edges and reads the banks at the next falling edge. romAddr has no register behind the banks, so it is checked in the same half cycle in which cpuAddr changes. Hold and stability checks wait several idle cycles with changed register inputs before they sample.

// File: rtl/mapperPkg.sv
package mapperPkg;
  typedef enum logic [1:0] {
    LK_WAIT_LOW  = 2'd0,
    LK_WAIT_HIGH = 2'd1,
    LK_OPEN      = 2'd2
  } lockState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // recompute banks this cycle
    logic holdBase;  // force banks 0/1 (lock closed after this update)
  } mapCmd_t;
endpackage

// File: rtl/unlockCtrl.sv
module unlockCtrl
  import mapperPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       updStrobe,
  input  logic       keyBit,
  output mapCmd_t    cmd,
  output lockState_t lockState
);
  lockState_t lockNext;

  always_comb begin
    lockNext = lockState;
    if (updStrobe) begin
      unique case (lockState)
        LK_WAIT_LOW:  if (!keyBit) lockNext = LK_WAIT_HIGH;
        LK_WAIT_HIGH: if (keyBit)  lockNext = LK_OPEN;
        default:                   lockNext = LK_OPEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockState <= LK_WAIT_LOW;
    else       lockState <= lockNext;
  end

  // the update that opens the lock already applies its own mapping
  always_comb begin
    cmd.load     = updStrobe;
    cmd.holdBase = (lockNext != LK_OPEN);
  end
endmodule

// File: rtl/bankCalc.sv
module bankCalc
  import mapperPkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int CTRL_W    = 5,
  parameter int PRG_W     = 4,
  parameter int INNER_W   = 3,
  parameter int OUTER_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapCmd_t           cmd,
  input  logic [CTRL_W-1:0] ctrlByte,
  input  logic [PRG_W-1:0]  prgBank,
  input  logic              prgMode,
  input  logic              bankSel,
  output logic [BANK_W-1:0] win0Bank,
  output logic [BANK_W-1:0] win1Bank
);
  localparam int NUM_WIN = 2;
  localparam logic [BANK_W-1:0] OUTER_VAL = BANK_W'(1) << OUTER_BIT;
  localparam logic [BANK_W-1:0] INNER_ALL = BANK_W'((1 << INNER_W) - 1);
  localparam logic [BANK_W-1:0] LSB_ONE   = BANK_W'(1);

  logic                outerOn;
  logic [BANK_W-1:0]   outerVal;
  logic [INNER_W-1:0]  innerSrc;
  logic [BANK_W-1:0]   innerVal;
  logic [BANK_W-1:0]   evenBank;
  logic [BANK_W-1:0]   nextBank [NUM_WIN];
  logic [BANK_W-1:0]   bankQ    [NUM_WIN];

  always_comb begin
    outerOn  = ctrlByte[OUTER_BIT];
    outerVal = outerOn ? OUTER_VAL : '0;
    innerSrc = outerOn ? prgBank[INNER_W-1:0] : ctrlByte[INNER_W-1:0];
    innerVal = BANK_W'(innerSrc);
    evenBank = (innerVal & ~LSB_ONE) | outerVal;
    if (cmd.holdBase) begin
      nextBank[0] = '0;
      nextBank[1] = LSB_ONE;
    end else if (prgMode && outerOn) begin
      if (bankSel) begin
        nextBank[0] = innerVal | outerVal;
        nextBank[1] = INNER_ALL | outerVal;
      end else begin
        nextBank[0] = outerVal;
        nextBank[1] = innerVal | outerVal;
      end
    end else begin
      nextBank[0] = evenBank;
      nextBank[1] = evenBank | LSB_ONE;
    end
  end

  // reset value equals the mapping of a 0x10 control byte: locked, banks 0/1
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN)         bankQ[w] <= BANK_W'(w);
      else if (cmd.load) bankQ[w] <= nextBank[w];
    end
  end

  assign win0Bank = bankQ[0];
  assign win1Bank = bankQ[1];
endmodule

// File: rtl/gated_prg_mapper.sv
module gated_prg_mapper
  import mapperPkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int OFFSET_W  = 14,
  parameter int CTRL_W    = 5,
  parameter int PRG_W     = 4,
  parameter int INNER_W   = 3,
  parameter int OUTER_BIT = 3,
  parameter int KEY_BIT   = 4,
  localparam int ROM_AW   = BANK_W + OFFSET_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              updStrobe,
  input  logic [CTRL_W-1:0] ctrlByte,
  input  logic [PRG_W-1:0]  prgBank,
  input  logic              prgMode,
  input  logic              bankSel,
  input  logic [OFFSET_W:0] cpuAddr,
  output logic [BANK_W-1:0] win0Bank,
  output logic [BANK_W-1:0] win1Bank,
  output logic [ROM_AW-1:0] romAddr
);
  mapCmd_t    cmd;
  lockState_t lockState;

  unlockCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .updStrobe (updStrobe),
    .keyBit    (ctrlByte[KEY_BIT]),
    .cmd       (cmd),
    .lockState (lockState)
  );

  bankCalc #(
    .BANK_W    (BANK_W),
    .CTRL_W    (CTRL_W),
    .PRG_W     (PRG_W),
    .INNER_W   (INNER_W),
    .OUTER_BIT (OUTER_BIT)
  ) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .ctrlByte (ctrlByte),
    .prgBank  (prgBank),
    .prgMode  (prgMode),
    .bankSel  (bankSel),
    .win0Bank (win0Bank),
    .win1Bank (win1Bank)
  );

  logic [BANK_W-1:0] liveBank;
  assign liveBank = cpuAddr[OFFSET_W] ? win1Bank : win0Bank;
  assign romAddr  = {liveBank, cpuAddr[OFFSET_W-1:0]};
endmodule

// File: rtl/mapperChecker.sv
module mapperChecker
  import mapperPkg::*;
#(
  parameter int BANK_W  = 4,
  parameter int CTRL_W  = 5,
  parameter int KEY_BIT = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              updStrobe,
  input logic [CTRL_W-1:0] ctrlByte,
  input logic [BANK_W-1:0] win0Bank,
  input logic [BANK_W-1:0] win1Bank,
  input lockState_t        lockState
);
  AST_RESET_BASE: assert property (@(posedge clk) $fell(rstN) |=> (win0Bank == '0 && win1Bank == BANK_W'(1) && lockState == LK_WAIT_LOW)); // R1

  AST_LOCKED_BASE: assert property (@(posedge clk) disable iff (!rstN)
    (lockState != LK_OPEN) |-> (win0Bank == '0 && win1Bank == BANK_W'(1))); // R2

  AST_ARM_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_WAIT_LOW && updStrobe && !ctrlByte[KEY_BIT]) |=> (lockState == LK_WAIT_HIGH)); // R3

  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_WAIT_LOW && !(updStrobe && !ctrlByte[KEY_BIT])) |=> (lockState == LK_WAIT_LOW)); // R3

  AST_OPEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_WAIT_HIGH && updStrobe && ctrlByte[KEY_BIT]) |=> (lockState == LK_OPEN)); // R4

  AST_OPEN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lockState == LK_OPEN) |=> (lockState == LK_OPEN)); // R5

  AST_BANKS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |=> ($stable(win0Bank) && $stable(win1Bank))); // R10
endmodule

bind gated_prg_mapper mapperChecker #(
  .BANK_W  (BANK_W),
  .CTRL_W  (CTRL_W),
  .KEY_BIT (KEY_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .updStrobe (updStrobe),
  .ctrlByte  (ctrlByte),
  .win0Bank  (win0Bank),
  .win1Bank  (win1Bank),
  .lockState (lockState)
);

// File: tb/sim_gated_prg_mapper.sv
`timescale 1ns/1ps
module sim_gated_prg_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        updStrobe = 1'b0;
  logic [4:0]  ctrlByte = '0;
  logic [3:0]  prgBank = '0;
  logic        prgMode = 1'b0;
  logic        bankSel = 1'b0;
  logic [14:0] cpuAddr = '0;
  logic [3:0]  win0Bank, win1Bank;
  logic [17:0] romAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gated_prg_mapper u0 (
    .clk(clk), .rstN(rstN), .updStrobe(updStrobe), .ctrlByte(ctrlByte),
    .prgBank(prgBank), .prgMode(prgMode), .bankSel(bankSel), .cpuAddr(cpuAddr),
    .win0Bank(win0Bank), .win1Bank(win1Bank), .romAddr(romAddr)
  );

  // {ctrl, prg, mode, sel, exp0, exp1}; applied while unlocked
  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {5'b00101, 4'd0,  1'b0, 1'b0, 4'd4,  4'd5 },  // R9 R6 outer 0, inner from ctrl
    {5'b01010, 4'd6,  1'b0, 1'b0, 4'd14, 4'd15},  // R9 R6 outer 8, inner from prg
    {5'b01000, 4'd3,  1'b1, 1'b1, 4'd11, 4'd15},  // R7
    {5'b01000, 4'd3,  1'b1, 1'b0, 4'd8,  4'd11},  // R8
    {5'b00011, 4'd7,  1'b1, 1'b1, 4'd2,  4'd3 },  // R9 mode set but outer 0
    {5'b11111, 4'd10, 1'b0, 1'b0, 4'd10, 4'd11},  // R6 prg bit 3 unused, R5 key=1
    {5'b11001, 4'd5,  1'b1, 1'b0, 4'd8,  4'd13},  // R8 R5
    {5'b00111, 4'd0,  1'b0, 1'b0, 4'd6,  4'd7 }   // R9 R5 key=0
  };

  task automatic checkBanks(string tag, logic [3:0] e0, logic [3:0] e1);
    total++;
    if (win0Bank !== e0 || win1Bank !== e1) begin
      bad++;
      $display("FAIL %s: banks actual=%0d/%0d expected=%0d/%0d", tag, win0Bank, win1Bank, e0, e1);
    end
  endtask

  task automatic checkRom(string tag, logic [17:0] e);
    total++;
    if (romAddr !== e) begin
      bad++;
      $display("FAIL %s: romAddr actual=%h expected=%h", tag, romAddr, e);
    end
  endtask

  // one-cycle strobe; result read at the following falling edge
  task automatic doUpdate(logic [4:0] c, logic [3:0] p, logic m, logic s);
    @(negedge clk);
    ctrlByte = c; prgBank = p; prgMode = m; bankSel = s; updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkBanks("R1 reset banks", 4'd0, 4'd1);
    rstN = 1'b1;
    @(negedge clk);

    // key bit high in first locked state: stays there
    doUpdate(5'b11010, 4'd6, 1'b0, 1'b0);
    checkBanks("R2 locked update", 4'd0, 4'd1);
    doUpdate(5'b10101, 4'd0, 1'b0, 1'b0);
    checkBanks("R3 high key ignored while waiting low", 4'd0, 4'd1);
    doUpdate(5'b00101, 4'd0, 1'b0, 1'b0);   // arms
    checkBanks("R2 armed still locked", 4'd0, 4'd1);
    doUpdate(5'b01000, 4'd3, 1'b1, 1'b1);   // low again: stays armed
    checkBanks("R4 low key while armed", 4'd0, 4'd1);
    doUpdate(5'b10101, 4'd0, 1'b0, 1'b0);   // opens, mapping applies now
    checkBanks("R4 unlock applies own mapping", 4'd4, 4'd5);

    for (int i = 0; i < NV; i++) begin
      doUpdate(VEC[i][18:14], VEC[i][13:10], VEC[i][9], VEC[i][8]);
      checkBanks($sformatf("R5/R6-R9 vector %0d", i), VEC[i][7:4], VEC[i][3:0]);
    end

    doUpdate(5'b01010, 4'd6, 1'b0, 1'b0);   // banks 14/15
    cpuAddr = 15'h4123;
    #1 checkRom("R11 window 1", {4'd15, 14'h0123});
    cpuAddr = 15'h0ABC;
    #1 checkRom("R11 window 0", {4'd14, 14'h0ABC});

    @(negedge clk);
    ctrlByte = 5'b00001; prgBank = 4'd1; prgMode = 1'b1; bankSel = 1'b1;
    repeat (4) @(negedge clk);
    checkBanks("R10 no strobe no change", 4'd14, 4'd15);

    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checkBanks("R1 reset after unlock", 4'd0, 4'd1);
    rstN = 1'b1;
    doUpdate(5'b10101, 4'd0, 1'b0, 1'b0);
    checkBanks("R1 relocked after reset", 4'd0, 4'd1);
    doUpdate(5'b00011, 4'd0, 1'b0, 1'b0);
    doUpdate(5'b11001, 4'd2, 1'b1, 1'b1);
    checkBanks("R4 reopen after reset", 4'd10, 4'd15);

    finishUp();
  end
endmodule